// File: doc/BRIEF.md
# Parallel Polyphase Decimating FIR Convolver

The block filters one sample stream that arrives split across `LANES` parallel lanes: on every accepted clock, lane `i` carries sample `k*LANES + i` of the stream, where `k` counts accepted blocks since reset. The impulse response of `LANES*SUB_TAPS` taps is held as `LANES` interleaved subsequences. Each subsequence is convolved with each lane, which gives `LANES²` subconvolutions per block. The full-rate output is rebuilt from these: an output sample takes a term from the current block when its lane index plus its subsequence index is less than `LANES`, and from the previous block when that sum wraps past `LANES`.

Only output samples whose stream index is a multiple of `DECIM` are kept. When `LANES` and `DECIM` are coprime, the positions of the kept samples inside a block change from block to block. A phase register tracks `(k*LANES) mod DECIM`. It is advanced on every accepted block and carried down the pipeline beside the data, so that each block is decoded with its own phase. Accumulation is full precision. Each kept sample is then rounded and saturated to the data width and presented in one of `SLOTS = ceil(LANES/DECIM)` output slots.

Coefficients are loaded through a one-word write port.

Top module: `poly_decim_conv`

## Requirements
- R1: While reset is held and after it is released, `valid_o` is all zeros and every `y_o` slot is zero. The history, the coefficients and the phase all start at zero.
- R2: A write with `coef_we_i` high stores `coef_data_i` as tap `t = coef_addr_i` of the impulse response `h`. Tap `t` belongs to subsequence `t mod LANES`, at position `t / LANES` within that subsequence.
- R3: In the `k`-th block accepted since reset, lane `i` is taken from `x_i[i*DATA_W +: DATA_W]` and is stream sample `x[k*LANES+i]`. Samples before the first accepted block count as zero.
- R4: Each produced sample equals the full-precision `y[n] = sum over t of h[t]*x[n-t]` for a stream index `n` that is a multiple of `DECIM`, before the rounding of R5 and the saturation of R6.
- R5: Rounding adds `2^(OUT_SHIFT-1)` and then shifts arithmetically right by `OUT_SHIFT`, so ties round toward plus infinity. With `OUT_SHIFT = 0` the sum passes through unchanged.
- R6: A rounded value above `2^(DATA_W-1)-1` or below `-2^(DATA_W-1)` is clamped to that bound.
- R7: The kept samples of one block fill the slots from slot 0 upward, in ascending stream index. Slot `s` is `y_o[s*DATA_W +: DATA_W]`, and `valid_o[s]` flags that slot. A set `valid_o` bit never has a clear bit below it.
- R8: The decimation grid runs on without a break across accepted blocks. Clocks with `valid_i` low neither advance the grid nor change the history, whatever the lanes carry.
- R9: The samples of a block accepted on rising edge E are on the outputs, with their valid bits, in the cycle after edge E+2.
- R10: `valid_o` is all zeros in any cycle that follows an edge that finished no sample. A slot whose valid bit is low keeps its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| coef_we_i | input | 1 | Coefficient write strobe |
| coef_addr_i | input | $clog2(LANES*SUB_TAPS) | Tap index to write |
| coef_data_i | input | COEF_W | Signed tap value |
| valid_i | input | 1 | Lanes carry a new block |
| x_i | input | LANES*DATA_W | Packed signed lane samples, lane 0 in the low bits |
| valid_o | output | SLOTS | Per-slot flag: a new decimated sample is present |
| y_o | output | SLOTS*DATA_W | Packed signed decimated samples, slot 0 in the low bits |

## Verification
The hardest case is a phase sequence in which a block yields fewer samples than there are slots, together with terms taken from the previous block. That previous block may be separated from the current one by idle clocks. The table stimulus mixes accepted blocks with idle clocks that carry nonzero lanes, so the phase has to survive the gaps and the wrap-around terms have to reach back past them. Impulses on single lanes map the coefficient addresses onto output positions. Large constant blocks of each sign drive both saturation bounds, and an identity filter with inputs on the rounding midpoint checks the tie rule.

// File: rtl/pdc_pkg.sv
package pdc_pkg;

  function automatic int ceil_div(input int a, input int b);
    return (a + b - 1) / b;
  endfunction

  function automatic int safe_clog2(input int v);
    return (v > 1) ? $clog2(v) : 1;
  endfunction

endpackage

// File: rtl/pdc_coef_bank.sv
module pdc_coef_bank #(
  parameter int LANES    = 4,
  parameter int SUB_TAPS = 4,
  parameter int COEF_W   = 16,
  parameter int AW       = 4
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     we_i,
  input  logic [AW-1:0]            addr_i,
  input  logic signed [COEF_W-1:0] data_i,
  output logic signed [COEF_W-1:0] coef_o [LANES][SUB_TAPS]
);
  localparam int TAPS = LANES * SUB_TAPS;

  logic signed [COEF_W-1:0] h_q [TAPS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int t = 0; t < TAPS; t++) h_q[t] <= '0;
    end else if (we_i && (32'(addr_i) < TAPS)) begin
      h_q[addr_i] <= data_i;
    end
  end

  // subsequence j, position m holds tap m*LANES + j
  for (genvar j = 0; j < LANES; j++) begin : g_sub
    for (genvar m = 0; m < SUB_TAPS; m++) begin : g_pos
      assign coef_o[j][m] = h_q[m*LANES + j];
    end
  end

  AST_COEF_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(h_q[0])) else $error("coef changed without write"); // R2

endmodule

// File: rtl/pdc_lane_hist.sv
module pdc_lane_hist #(
  parameter int LANES    = 4,
  parameter int SUB_TAPS = 4,
  parameter int DATA_W   = 16,
  parameter int DECIM    = 3,
  parameter int PH_W     = 2
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     valid_i,
  input  logic signed [DATA_W-1:0] lane_i [LANES],
  output logic signed [DATA_W-1:0] hist_o [LANES][SUB_TAPS],
  output logic                     valid_o,
  output logic [PH_W-1:0]          phase_o
);
  localparam int STEP = LANES % DECIM;

  logic [PH_W-1:0] phase_q;
  logic [PH_W:0]   phase_sum;

  assign phase_sum = {1'b0, phase_q} + (PH_W+1)'(STEP);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < LANES; i++)
        for (int m = 0; m < SUB_TAPS; m++) hist_o[i][m] <= '0;
      phase_q <= '0;
      phase_o <= '0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        for (int i = 0; i < LANES; i++) begin
          hist_o[i][0] <= lane_i[i];
          for (int m = 1; m < SUB_TAPS; m++) hist_o[i][m] <= hist_o[i][m-1];
        end
        phase_o <= phase_q;
        phase_q <= (phase_sum >= (PH_W+1)'(DECIM)) ?
                   PH_W'(phase_sum - (PH_W+1)'(DECIM)) : PH_W'(phase_sum);
      end
    end
  end

  AST_PHASE_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(phase_q) < DECIM) else $error("phase out of range"); // R8
  AST_PHASE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(phase_q)) else $error("phase moved on idle"); // R8
  AST_HIST_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(hist_o[0][0])) else $error("history moved on idle"); // R8

endmodule

// File: rtl/pdc_subconv.sv
module pdc_subconv #(
  parameter int LANES    = 4,
  parameter int SUB_TAPS = 4,
  parameter int DATA_W   = 16,
  parameter int COEF_W   = 16,
  parameter int SUB_W    = 34,
  parameter int PH_W     = 2
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     valid_i,
  input  logic [PH_W-1:0]          phase_i,
  input  logic signed [DATA_W-1:0] hist_i [LANES][SUB_TAPS],
  input  logic signed [COEF_W-1:0] coef_i [LANES][SUB_TAPS],
  output logic signed [SUB_W-1:0]  cur_o  [LANES][LANES],
  output logic signed [SUB_W-1:0]  prev_o [LANES][LANES],
  output logic                     valid_o,
  output logic [PH_W-1:0]          phase_o
);
  logic signed [SUB_W-1:0] sub_c [LANES][LANES];

  // sub_c[i][j]: lane i history convolved with subsequence j
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    for (genvar j = 0; j < LANES; j++) begin : g_sub
      always_comb begin
        sub_c[i][j] = '0;
        for (int m = 0; m < SUB_TAPS; m++)
          sub_c[i][j] = sub_c[i][j] + (SUB_W'(hist_i[i][m]) * SUB_W'(coef_i[j][m]));
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < LANES; i++)
        for (int j = 0; j < LANES; j++) begin
          cur_o[i][j]  <= '0;
          prev_o[i][j] <= '0;
        end
      valid_o <= 1'b0;
      phase_o <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        phase_o <= phase_i;
        for (int i = 0; i < LANES; i++)
          for (int j = 0; j < LANES; j++) begin
            cur_o[i][j]  <= sub_c[i][j];
            prev_o[i][j] <= cur_o[i][j];
          end
      end
    end
  end

  AST_SUB_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(prev_o[LANES-1][LANES-1])) else $error("carry stage moved"); // R8

endmodule

// File: rtl/pdc_recombine.sv
module pdc_recombine #(
  parameter int LANES     = 4,
  parameter int DECIM     = 3,
  parameter int DATA_W    = 16,
  parameter int SUB_W     = 34,
  parameter int ACC_W     = 37,
  parameter int OUT_SHIFT = 15,
  parameter int SLOTS     = 2,
  parameter int PH_W      = 2
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    valid_i,
  input  logic [PH_W-1:0]         phase_i,
  input  logic signed [SUB_W-1:0] cur_i  [LANES][LANES],
  input  logic signed [SUB_W-1:0] prev_i [LANES][LANES],
  output logic [SLOTS-1:0]        valid_o,
  output logic signed [DATA_W-1:0] y_o  [SLOTS]
);
  localparam logic signed [ACC_W-1:0] RND =
    (OUT_SHIFT > 0) ? (ACC_W'(1) << (OUT_SHIFT - 1)) : '0;
  localparam logic signed [ACC_W-1:0] MAX_V = ACC_W'((64'sd1 <<< (DATA_W-1)) - 1);
  localparam logic signed [ACC_W-1:0] MIN_V = -MAX_V - 1;

  logic signed [ACC_W-1:0] part   [LANES][LANES+1];
  logic signed [ACC_W-1:0] full_c [LANES];
  logic signed [ACC_W-1:0] slot_v [SLOTS][DECIM];
  logic                    slot_k [SLOTS][DECIM];

  // output r of a block: lane i with subsequence (r-i) mod LANES,
  // previous block when i+j wraps past LANES
  for (genvar r = 0; r < LANES; r++) begin : g_out
    assign part[r][0] = '0;
    for (genvar i = 0; i < LANES; i++) begin : g_term
      localparam int J = (r - i + LANES) % LANES;
      if (i <= r) begin : g_now
        assign part[r][i+1] = part[r][i] + ACC_W'(cur_i[i][J]);
      end else begin : g_carry
        assign part[r][i+1] = part[r][i] + ACC_W'(prev_i[i][J]);
      end
    end
    assign full_c[r] = part[r][LANES];
  end

  // per phase p, first kept output sits at (DECIM-p) mod DECIM
  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    for (genvar p = 0; p < DECIM; p++) begin : g_ph
      localparam int R = ((DECIM - p) % DECIM) + s * DECIM;
      if (R < LANES) begin : g_hit
        assign slot_v[s][p] = full_c[R];
        assign slot_k[s][p] = 1'b1;
      end else begin : g_miss
        assign slot_v[s][p] = '0;
        assign slot_k[s][p] = 1'b0;
      end
    end
  end

  function automatic logic signed [DATA_W-1:0] rnd_sat(input logic signed [ACC_W-1:0] a);
    logic signed [ACC_W-1:0] b;
    b = (a + RND) >>> OUT_SHIFT;
    if (b > MAX_V)      return MAX_V[DATA_W-1:0];
    else if (b < MIN_V) return MIN_V[DATA_W-1:0];
    else                return b[DATA_W-1:0];
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= '0;
      for (int s = 0; s < SLOTS; s++) y_o[s] <= '0;
    end else begin
      for (int s = 0; s < SLOTS; s++) begin
        valid_o[s] <= valid_i && slot_k[s][phase_i];
        if (valid_i && slot_k[s][phase_i]) y_o[s] <= rnd_sat(slot_v[s][phase_i]);
      end
    end
  end

  AST_NO_SPURIOUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> valid_o == '0) else $error("valid without block"); // R10

  for (genvar s = 0; s < SLOTS; s++) begin : g_chk
    AST_SLOT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !valid_o[s] |-> $stable(y_o[s])) else $error("slot changed while idle"); // R10
    if (s > 0) begin : g_pack
      AST_SLOT_PACKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        valid_o[s] |-> valid_o[s-1]) else $error("slot gap"); // R7
    end
  end

  if (LANES >= DECIM) begin : g_yield
    AST_BLOCK_YIELDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      valid_i |=> valid_o[0]) else $error("block produced nothing"); // R8
  end

endmodule

// File: rtl/poly_decim_conv.sv
module poly_decim_conv #(
  parameter int LANES     = 4,
  parameter int DECIM     = 3,
  parameter int SUB_TAPS  = 4,
  parameter int DATA_W    = 16,
  parameter int COEF_W    = 16,
  parameter int OUT_SHIFT = 15
) (
  input  logic                                        clk_i,
  input  logic                                        rst_ni,
  input  logic                                        coef_we_i,
  input  logic [$clog2(LANES*SUB_TAPS)-1:0]           coef_addr_i,
  input  logic [COEF_W-1:0]                           coef_data_i,
  input  logic                                        valid_i,
  input  logic [LANES*DATA_W-1:0]                     x_i,
  output logic [pdc_pkg::ceil_div(LANES, DECIM)-1:0]  valid_o,
  output logic [pdc_pkg::ceil_div(LANES, DECIM)*DATA_W-1:0] y_o
);
  localparam int TAPS  = LANES * SUB_TAPS;
  localparam int AW    = $clog2(TAPS);
  localparam int SLOTS = pdc_pkg::ceil_div(LANES, DECIM);
  localparam int PH_W  = pdc_pkg::safe_clog2(DECIM);
  localparam int PROD_W = DATA_W + COEF_W;
  localparam int SUB_W  = PROD_W + pdc_pkg::safe_clog2(SUB_TAPS);
  localparam int ACC_W  = SUB_W + pdc_pkg::safe_clog2(LANES) + 1;

  logic signed [DATA_W-1:0] lane   [LANES];
  logic signed [DATA_W-1:0] hist   [LANES][SUB_TAPS];
  logic signed [COEF_W-1:0] coef   [LANES][SUB_TAPS];
  logic signed [SUB_W-1:0]  sub_cur  [LANES][LANES];
  logic signed [SUB_W-1:0]  sub_prev [LANES][LANES];
  logic signed [DATA_W-1:0] y_slot [SLOTS];
  logic                     v0, v1;
  logic [PH_W-1:0]          ph0, ph1;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign lane[i] = x_i[i*DATA_W +: DATA_W];
  end

  for (genvar s = 0; s < SLOTS; s++) begin : g_out
    assign y_o[s*DATA_W +: DATA_W] = y_slot[s];
  end

  pdc_coef_bank #(
    .LANES(LANES), .SUB_TAPS(SUB_TAPS), .COEF_W(COEF_W), .AW(AW)
  ) u_coef (
    .clk_i, .rst_ni,
    .we_i   (coef_we_i),
    .addr_i (coef_addr_i),
    .data_i (coef_data_i),
    .coef_o (coef)
  );

  pdc_lane_hist #(
    .LANES(LANES), .SUB_TAPS(SUB_TAPS), .DATA_W(DATA_W), .DECIM(DECIM), .PH_W(PH_W)
  ) u_hist (
    .clk_i, .rst_ni,
    .valid_i (valid_i),
    .lane_i  (lane),
    .hist_o  (hist),
    .valid_o (v0),
    .phase_o (ph0)
  );

  pdc_subconv #(
    .LANES(LANES), .SUB_TAPS(SUB_TAPS), .DATA_W(DATA_W), .COEF_W(COEF_W),
    .SUB_W(SUB_W), .PH_W(PH_W)
  ) u_sub (
    .clk_i, .rst_ni,
    .valid_i (v0),
    .phase_i (ph0),
    .hist_i  (hist),
    .coef_i  (coef),
    .cur_o   (sub_cur),
    .prev_o  (sub_prev),
    .valid_o (v1),
    .phase_o (ph1)
  );

  pdc_recombine #(
    .LANES(LANES), .DECIM(DECIM), .DATA_W(DATA_W), .SUB_W(SUB_W), .ACC_W(ACC_W),
    .OUT_SHIFT(OUT_SHIFT), .SLOTS(SLOTS), .PH_W(PH_W)
  ) u_rec (
    .clk_i, .rst_ni,
    .valid_i (v1),
    .phase_i (ph1),
    .cur_i   (sub_cur),
    .prev_i  (sub_prev),
    .valid_o (valid_o),
    .y_o     (y_slot)
  );

  AST_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o != '0 |-> $past(valid_i, 3)) else $error("output without input 3 cycles ago"); // R9

endmodule

// File: tb/poly_decim_conv_tb.sv
module poly_decim_conv_tb;
  localparam int P = 4, D = 3, M = 4, W = 16, SH = 2;
  localparam int TAPS = P * M;
  localparam int S = (P + D - 1) / D;
  localparam int NSTIM = 12;
  // valid, lane0..lane3
  localparam int STIM [NSTIM][P+1] = '{
    '{1,  10, -20,  30, -40}, '{1,  55,  -7,  12,  99},
    '{0, 500, 500, 500, 500}, '{1, -60,  44, -13,   8},
    '{1,  77, -88,  21,   3}, '{0,-300, 300,-300, 300},
    '{0, 123, 456, 789, 321}, '{1,  -5,  -9,  64, -64},
    '{1, 100,-100,  50, -25}, '{1,  17,  19,  23,  29},
    '{0,  99,  99,  99,  99}, '{1, -31,  62, -93,  11}};

  logic clk_i = 0, rst_ni = 0, coef_we_i = 0, valid_i = 0;
  logic [$clog2(TAPS)-1:0] coef_addr_i = '0;
  logic [W-1:0] coef_data_i = '0;
  logic [P*W-1:0] x_i = '0;
  logic [S-1:0] valid_o;
  logic [S*W-1:0] y_o;

  int n_chk = 0, n_bad = 0, nblk = 0;
  int xs [0:255];
  int hs [TAPS];
  int pend [3];
  int last_y [S];
  bit done = 0;

  always #2 clk_i = ~clk_i;

  poly_decim_conv #(.LANES(P), .DECIM(D), .SUB_TAPS(M), .DATA_W(W),
                    .COEF_W(W), .OUT_SHIFT(SH)) u_dut (
    .clk_i, .rst_ni, .coef_we_i, .coef_addr_i, .coef_data_i,
    .valid_i, .x_i, .valid_o, .y_o);

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic longint model_y(input int n);
    longint acc = 0;
    for (int t = 0; t < TAPS; t++)
      if (n - t >= 0) acc += longint'(hs[t]) * longint'(xs[n-t]);
    return acc;
  endfunction

  function automatic int rnd_sat(input longint a);
    longint b = (a + ((SH > 0) ? (64'sd1 <<< (SH-1)) : 0)) >>> SH;
    if (b > 32767) return 32767;
    if (b < -32768) return -32768;
    return int'(b);
  endfunction

  task automatic reset_dut();
    rst_ni = 0; valid_i = 0; coef_we_i = 0;
    repeat (2) @(negedge clk_i);
    check("R1 valid_o in reset", int'(valid_o), 0);
    rst_ni = 1;
    @(negedge clk_i);
    check("R1 valid_o after reset", int'(valid_o), 0);
    for (int s = 0; s < S; s++) begin
      check("R1 y_o after reset", int'($signed(y_o[s*W +: W])), 0);
      last_y[s] = 0;
    end
    for (int i = 0; i < 3; i++) pend[i] = -1;
    nblk = 0;
  endtask

  task automatic load_coefs();
    for (int t = 0; t < TAPS; t++) begin
      coef_we_i = 1; coef_addr_i = t[$clog2(TAPS)-1:0]; coef_data_i = hs[t][W-1:0];
      @(negedge clk_i);
    end
    coef_we_i = 0;
  endtask

  // check block accepted three edges ago, then drive the next clock
  task automatic step(input bit v, input int l0, input int l1, input int l2,
                      input int l3, input string tag);
    int k, ev, s;
    int ey [S];
    k = pend[2];
    ev = 0;
    for (int q = 0; q < S; q++) ey[q] = last_y[q];
    if (k >= 0) begin
      s = 0;
      for (int r = 0; r < P; r++) begin
        if (((k * P + r) % D) == 0) begin
          ev |= (1 << s);
          ey[s] = rnd_sat(model_y(k * P + r));
          s++;
        end
      end
    end
    check({tag, " R9 R10 valid_o"}, int'(valid_o), ev);
    for (int q = 0; q < S; q++) begin
      check({tag, " R4 R7 y_o slot"}, int'($signed(y_o[q*W +: W])), ey[q]);
      last_y[q] = ey[q];
    end
    pend[2] = pend[1]; pend[1] = pend[0];
    if (v) begin
      xs[nblk*P+0] = l0; xs[nblk*P+1] = l1; xs[nblk*P+2] = l2; xs[nblk*P+3] = l3;
      pend[0] = nblk;
      nblk++;
    end else pend[0] = -1;
    valid_i = v;
    x_i = {l3[W-1:0], l2[W-1:0], l1[W-1:0], l0[W-1:0]};
    @(negedge clk_i);
  endtask

  task automatic drain(input string tag);
    repeat (4) step(0, 7, -7, 7, -7, tag);
  endtask

  initial begin
    @(negedge clk_i);
    // table run: mixed blocks and idle clocks (R3 R8)
    for (int t = 0; t < TAPS; t++) hs[t] = ((t * 13 + 5) % 31) - 15;
    reset_dut();
    load_coefs();
    for (int r = 0; r < NSTIM; r++)
      step(STIM[r][0] != 0, STIM[r][1], STIM[r][2], STIM[r][3], STIM[r][4], "R8 table");
    drain("R8 table");

    // impulse on lane 0 exposes tap addresses (R2)
    reset_dut();
    load_coefs();
    step(1, 4, 0, 0, 0, "R2 impulse");
    repeat (5) step(1, 0, 0, 0, 0, "R2 impulse");
    drain("R2 impulse");

    // impulse on lane 1 (R3)
    reset_dut();
    load_coefs();
    step(1, 0, 4, 0, 0, "R3 lane1");
    repeat (5) step(1, 0, 0, 0, 0, "R3 lane1");
    drain("R3 lane1");

    // identity filter, inputs on rounding ties (R5)
    for (int t = 0; t < TAPS; t++) hs[t] = (t == 0) ? 1 : 0;
    reset_dut();
    load_coefs();
    step(1, 2, 0, 0, -2, "R5 round");
    step(1, 0, 0, 6, 0, "R5 round");
    step(1, 0, -6, 0, 0, "R5 round");
    step(1, 10, 0, 0, -10, "R5 round");
    drain("R5 round");

    // large sums of both signs (R6)
    for (int t = 0; t < TAPS; t++) hs[t] = 30000;
    reset_dut();
    load_coefs();
    repeat (5) step(1, 30000, 30000, 30000, 30000, "R6 sat");
    repeat (6) step(1, -30000, -30000, -30000, -30000, "R6 sat");
    drain("R6 sat");
    check("R6 low bound", int'($signed(y_o[0 +: W])), -32768);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule